// File: doc/BRIEF.md
# Sensor Sample Decoder with Temperature Alarms

This block sits behind a four-channel sensor converter. The converter delivers three supply-rail voltages and the die temperature. Each conversion arrives as a 16-bit word with a 2-bit channel tag and a one-cycle valid strobe. The block accepts a word only when its channel is enabled. It keeps the last accepted word for each channel in its own register and pulses a per-channel update flag when that register changes. It presents the held words as fixed-point fields: millivolts with a sign for the rails, and kelvin for the temperature.

Each accepted temperature word is compared with a programmed high limit and a programmed low limit. A word above the high limit sets a sticky high alarm. A word below the low limit sets a sticky low alarm. Each alarm has its own clear input. A clear is honoured only when the most recent temperature is back inside the window. A clear that is held high takes effect on the first cycle in which that is true. A status output shows that the latest temperature lies inside the window.

Top module: `sensor_sample_decoder`

## Requirements
- R1: Channel codes are 0 = 1.0 V rail, 1 = 1.8 V rail, 2 = 2.5 V rail and 3 = die temperature. A sample taken with `smp_valid` high on a clock edge, with its channel enabled, is stored in that channel's register. In the next cycle `rd_upd` bit [code] is high for exactly one cycle, and no other bit of `rd_upd` is high.
- R2: For the rail channels, bit 15 of the stored word appears on `volt_neg`, bits [14:3] (whole millivolts) on `volt_mv`, and bits [2:0] (eighths of a millivolt) on `volt_frac`. Rail n occupies slice n of each bus. For example, 0x385E gives 1803 mV and fraction 6.
- R3: For the temperature channel, bits [14:4] (whole kelvin) appear on `temp_k` and bits [3:0] (sixteenths of a kelvin) on `temp_frac`. Bit 15 is ignored. For example, 0x133B gives 307 K and fraction 11.
- R4: While `smp_valid` is low, changes on `smp_chan` and `smp_data` do not alter any stored reading, and no update pulse is produced.
- R5: A sample whose channel bit in `chan_en` is low is discarded even with `smp_valid` high. It stores nothing, produces no pulse and does not touch the alarms.
- R6: `alarm_hi` is set in the cycle after an accepted temperature sample with bits [14:0] strictly greater than `thr_hi`, compared unsigned in 1/16 K units. A sample equal to `thr_hi` does not set it.
- R7: `alarm_lo` is set in the cycle after an accepted temperature sample with bits [14:0] strictly less than `thr_lo`, compared unsigned. A sample equal to `thr_lo` does not set it.
- R8: Both alarms are sticky. A clear request is refused while the most recent accepted temperature is still beyond that alarm's limit.
- R9: A clear input held high clears its alarm on the first clock edge at which the latest temperature is back inside the limit, including the edge that accepts that in-range sample.
- R10: `temp_ok` is high once at least one temperature sample has been accepted and the latest one satisfies thr_lo <= t <= thr_hi. Otherwise it is low.
- R11: After reset all stored readings, update pulses, alarms and `temp_ok` are zero.
- R12: The two alarms are independent. `clr_hi` never changes `alarm_lo`, and `clr_lo` never changes `alarm_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_chan | input | 2 | Channel tag of the sample |
| smp_data | input | 16 | Raw sample word |
| chan_en | input | 4 | Per-channel enable, bit index = channel code |
| thr_hi | input | 15 | High temperature limit, 1/16 K |
| thr_lo | input | 15 | Low temperature limit, 1/16 K |
| clr_hi | input | 1 | Request to clear the high alarm |
| clr_lo | input | 1 | Request to clear the low alarm |
| rd_upd | output | 4 | One-cycle update pulse per channel |
| volt_neg | output | 3 | Sign bit per rail |
| volt_mv | output | 36 | Whole millivolts, 12 bits per rail |
| volt_frac | output | 9 | Eighths of a millivolt, 3 bits per rail |
| temp_k | output | 11 | Whole kelvin of the held temperature |
| temp_frac | output | 4 | Sixteenths of a kelvin |
| alarm_hi | output | 1 | Sticky over-temperature flag |
| alarm_lo | output | 1 | Sticky under-temperature flag |
| temp_ok | output | 1 | Latest temperature inside the window |

## Verification
The checker watches several properties on every cycle. It checks that update pulses are one-hot and follow only enabled, strobed samples. It checks that a disabled or unstrobed sample leaves every pulse low. It checks that a held temperature matches the sample that produced its pulse. It checks that an out-of-window sample raises the matching alarm, that an alarm holds without a clear, and that an alarm falls only after a clear request. The bench scenarios are needed for the rest. They show the decoded field values of specific words, the equal-to-limit boundaries, and that a clear is refused while the temperature is still out of range. They also show that a held clear takes effect on exactly the in-range edge, and that one clear input does not affect the other alarm.

// File: rtl/sensor_dec_pkg.sv
// Package: shared channel encoding and default field widths for the
// sensor sample decoder. Assumes channel codes are dense from zero with the
// temperature channel last.
package sensor_dec_pkg;

    localparam int SD_DATA_W  = 16;
    localparam int SD_VFRAC_W = 3;
    localparam int SD_TFRAC_W = 4;
    localparam int SD_NRAIL   = 3;

    typedef enum logic [1:0] {
        CH_RAIL_1V0 = 2'd0,
        CH_RAIL_1V8 = 2'd1,
        CH_RAIL_2V5 = 2'd2,
        CH_DIE_TEMP = 2'd3
    } sd_chan_e;

endpackage

// File: rtl/sdec_accept.sv
// Module: sdec_accept
// Turns the strobe, channel tag and enable mask into a one-hot accept vector.
// Assumes the tag is only meaningful while the strobe is high.
module sdec_accept #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            valid,
    input  logic [CH_W-1:0] chan,
    input  logic [NCH-1:0]  en,
    output logic [NCH-1:0]  acc
);

    // Decode the tag and gate it with the strobe and the channel's enable.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            acc[i] = valid && (chan == CH_W'(i)) && en[i];
        end
    end

endmodule

// File: rtl/sdec_bank.sv
// Module: sdec_bank
// One holding register per channel plus a registered one-cycle update pulse.
// Assumes the accept vector is at most one-hot.
module sdec_bank #(
    parameter int NCH    = 4,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             acc,
    input  logic [DATA_W-1:0]          data,
    output logic [NCH-1:0][DATA_W-1:0] held,
    output logic [NCH-1:0]             upd
);

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        // Capture the word for this channel and flag that it changed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[g] <= '0;
                upd[g]  <= 1'b0;
            end else begin
                upd[g] <= acc[g];
                if (acc[g]) begin
                    held[g] <= data;
                end
            end
        end
    end

endmodule

// File: rtl/sdec_alarm.sv
// Module: sdec_alarm
// Window comparison of accepted temperature samples with sticky high/low
// alarms. A clear is honoured only when the latest temperature is inside that
// alarm's limit; a new sample on the same edge is taken as the latest.
// Assumes thresholds use the same unsigned 1/16 K format as the sample.
module sdec_alarm #(
    parameter int T_W = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_t,
    input  logic [T_W-1:0] t_smp,
    input  logic [T_W-1:0] thr_hi,
    input  logic [T_W-1:0] thr_lo,
    input  logic           clr_hi,
    input  logic           clr_lo,
    output logic           alarm_hi,
    output logic           alarm_lo,
    output logic           temp_ok
);

    logic over_now, under_now;
    logic over_lat, under_lat, seen;
    logic over_eff, under_eff;

    // Compare the incoming sample with both limits.
    always_comb begin
        over_now  = t_smp > thr_hi;
        under_now = t_smp < thr_lo;
        over_eff  = acc_t ? over_now  : over_lat;
        under_eff = acc_t ? under_now : under_lat;
    end

    // Remember where the latest accepted temperature lies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_lat  <= 1'b0;
            under_lat <= 1'b0;
            seen      <= 1'b0;
        end else if (acc_t) begin
            over_lat  <= over_now;
            under_lat <= under_now;
            seen      <= 1'b1;
        end
    end

    // Sticky alarms: set on violation, clear only on request while in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_hi <= 1'b0;
            alarm_lo <= 1'b0;
        end else begin
            alarm_hi <= (acc_t && over_now)  || (alarm_hi && !(clr_hi && !over_eff));
            alarm_lo <= (acc_t && under_now) || (alarm_lo && !(clr_lo && !under_eff));
        end
    end

    // In-window status of the latest sample.
    always_comb begin
        temp_ok = seen && !over_lat && !under_lat;
    end

endmodule

// File: rtl/sensor_sample_decoder.sv
// Module: sensor_sample_decoder (top)
// Accepts tagged converter samples, holds the latest per channel, exposes
// them as fixed-point fields and drives temperature window alarms.
// Assumes the temperature channel has the highest channel code.
module sensor_sample_decoder #(
    parameter int DATA_W  = sensor_dec_pkg::SD_DATA_W,
    parameter int VFRAC_W = sensor_dec_pkg::SD_VFRAC_W,
    parameter int TFRAC_W = sensor_dec_pkg::SD_TFRAC_W,
    parameter int NRAIL   = sensor_dec_pkg::SD_NRAIL,
    localparam int NCH    = NRAIL + 1,
    localparam int CH_W   = $clog2(NCH),
    localparam int VINT_W = DATA_W - 1 - VFRAC_W,
    localparam int TINT_W = DATA_W - 1 - TFRAC_W,
    localparam int T_W    = DATA_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_valid,
    input  logic [CH_W-1:0]           smp_chan,
    input  logic [DATA_W-1:0]         smp_data,
    input  logic [NCH-1:0]            chan_en,
    input  logic [T_W-1:0]            thr_hi,
    input  logic [T_W-1:0]            thr_lo,
    input  logic                      clr_hi,
    input  logic                      clr_lo,
    output logic [NCH-1:0]            rd_upd,
    output logic [NRAIL-1:0]          volt_neg,
    output logic [NRAIL*VINT_W-1:0]   volt_mv,
    output logic [NRAIL*VFRAC_W-1:0]  volt_frac,
    output logic [TINT_W-1:0]         temp_k,
    output logic [TFRAC_W-1:0]        temp_frac,
    output logic                      alarm_hi,
    output logic                      alarm_lo,
    output logic                      temp_ok
);

    localparam int TEMP_CH = NRAIL;

    logic [NCH-1:0]             acc;
    logic [NCH-1:0][DATA_W-1:0] held;

    sdec_accept #(.NCH(NCH), .CH_W(CH_W)) u_accept (
        .valid (smp_valid),
        .chan  (smp_chan),
        .en    (chan_en),
        .acc   (acc)
    );

    sdec_bank #(.NCH(NCH), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .data  (smp_data),
        .held  (held),
        .upd   (rd_upd)
    );

    sdec_alarm #(.T_W(T_W)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_t    (acc[TEMP_CH]),
        .t_smp    (smp_data[T_W-1:0]),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .clr_hi   (clr_hi),
        .clr_lo   (clr_lo),
        .alarm_hi (alarm_hi),
        .alarm_lo (alarm_lo),
        .temp_ok  (temp_ok)
    );

    for (genvar r = 0; r < NRAIL; r++) begin : g_rail
        // Split a held rail word into sign, whole and fractional millivolts.
        always_comb begin
            volt_neg[r]                    = held[r][DATA_W-1];
            volt_mv[r*VINT_W +: VINT_W]    = held[r][DATA_W-2:VFRAC_W];
            volt_frac[r*VFRAC_W +: VFRAC_W] = held[r][VFRAC_W-1:0];
        end
    end

    // Split the held temperature word into whole and fractional kelvin.
    always_comb begin
        temp_k    = held[TEMP_CH][DATA_W-2:TFRAC_W];
        temp_frac = held[TEMP_CH][TFRAC_W-1:0];
    end

endmodule

// File: rtl/sensor_sample_decoder_chk.sv
// Module: sensor_sample_decoder_chk
// Cycle-by-cycle properties on the decoder's ports, bound into the top.
module sensor_sample_decoder_chk #(
    parameter int DATA_W  = 16,
    parameter int TFRAC_W = 4,
    parameter int NRAIL   = 3,
    localparam int NCH    = NRAIL + 1,
    localparam int CH_W   = $clog2(NCH),
    localparam int TINT_W = DATA_W - 1 - TFRAC_W,
    localparam int T_W    = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [CH_W-1:0]   smp_chan,
    input logic [DATA_W-1:0] smp_data,
    input logic [NCH-1:0]    chan_en,
    input logic [T_W-1:0]    thr_hi,
    input logic [T_W-1:0]    thr_lo,
    input logic              clr_hi,
    input logic              clr_lo,
    input logic [NCH-1:0]    rd_upd,
    input logic [TINT_W-1:0] temp_k,
    input logic              alarm_hi,
    input logic              alarm_lo
);

    localparam logic [CH_W-1:0] TCODE = CH_W'(NRAIL);

    // R1
    upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_upd));

    // R4
    no_strobe_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> rd_upd == '0);

    // R5
    disabled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !chan_en[smp_chan]) |=> rd_upd == '0);

    // R3
    temp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == TCODE && chan_en[NRAIL])
        |=> (rd_upd[NRAIL] && temp_k == $past(smp_data[DATA_W-2:TFRAC_W])));

    // R6
    hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == TCODE && chan_en[NRAIL] && smp_data[T_W-1:0] > thr_hi)
        |=> alarm_hi);

    // R7
    lo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == TCODE && chan_en[NRAIL] && smp_data[T_W-1:0] < thr_lo)
        |=> alarm_lo);

    // R8
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_hi && !clr_hi) |=> alarm_hi);

    // R8
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_lo && !clr_lo) |=> alarm_lo);

endmodule

bind sensor_sample_decoder sensor_sample_decoder_chk #(
    .DATA_W  (DATA_W),
    .TFRAC_W (TFRAC_W),
    .NRAIL   (NRAIL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .smp_data  (smp_data),
    .chan_en   (chan_en),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .clr_hi    (clr_hi),
    .clr_lo    (clr_lo),
    .rd_upd    (rd_upd),
    .temp_k    (temp_k),
    .alarm_hi  (alarm_hi),
    .alarm_lo  (alarm_lo)
);

// File: tb/sensor_sample_decoder_tb_top.sv
// Scoreboard bench: the driver queues the expected channel and word for every
// sample it sends; a monitor pops and compares on each update pulse.
module sensor_sample_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_chan = '0;
    logic [15:0] smp_data = '0;
    logic [3:0]  chan_en = 4'hF;
    logic [14:0] thr_hi = 15'd5280;  // 330 K
    logic [14:0] thr_lo = 15'd4000;  // 250 K
    logic        clr_hi = 1'b0;
    logic        clr_lo = 1'b0;
    logic [3:0]  rd_upd;
    logic [2:0]  volt_neg;
    logic [35:0] volt_mv;
    logic [8:0]  volt_frac;
    logic [10:0] temp_k;
    logic [3:0]  temp_frac;
    logic        alarm_hi, alarm_lo, temp_ok;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;
    int exp_ch[$];
    logic [15:0] exp_val[$];

    always #10 clk = ~clk;

    sensor_sample_decoder dut_i (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
        nvec++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] reading(input int ch);
        if (ch < 3) return {volt_neg[ch], volt_mv[ch*12 +: 12], volt_frac[ch*3 +: 3]};
        return {1'b0, temp_k, temp_frac};
    endfunction

    // Driver: one-cycle strobe; expected item queued only for enabled channels.
    task automatic send(input int ch, input logic [15:0] d, input bit strobe = 1);
        @(negedge clk);
        smp_valid = strobe;
        smp_chan  = 2'(ch);
        smp_data  = d;
        if (strobe && chan_en[ch]) begin
            exp_ch.push_back(ch);
            exp_val.push_back(ch == 3 ? {1'b0, d[14:0]} : d);
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Monitor: compare each update pulse against the queue front.
    always @(negedge clk) begin
        if (rst_n && rd_upd != 4'b0) begin
            if (exp_ch.size() == 0) begin
                check(32'(rd_upd), 32'h0, "R5 unexpected update pulse");
            end else begin
                int c;
                logic [15:0] v;
                c = exp_ch.pop_front();
                v = exp_val.pop_front();
                check(32'(rd_upd), 32'(1) << c, "R1 update pulse channel");
                check(32'(reading(c)), 32'(v), c == 3 ? "R3 temperature fields" : "R2 voltage fields");
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(32'({rd_upd, volt_neg, alarm_hi, alarm_lo, temp_ok}), 0, "R11 reset flags");
        check(32'(volt_mv), 0, "R11 reset mv");
        check(32'({temp_k, temp_frac}), 0, "R11 reset temp");
        rst_n = 1'b1;

        // R2 example rail word and others
        send(1, 16'h385E);
        check(32'(volt_mv[12 +: 12]), 1803, "R2 1.8V whole mV");
        check(32'(volt_frac[3 +: 3]), 6, "R2 1.8V fraction");
        send(0, 16'h8010);
        check(32'(volt_neg[0]), 1, "R2 sign bit");
        send(2, 16'h4E21);
        // R3 example temperature word, reserved bit ignored
        send(3, 16'h933B);
        check(32'(temp_k), 307, "R3 whole kelvin");
        check(32'(temp_frac), 11, "R3 fraction");
        check(32'(temp_ok), 1, "R10 in window");

        // R4 no strobe: nothing changes
        send(3, 16'h0100, 0);
        send(0, 16'h1234, 0);
        check(32'(reading(3)), 32'h133B, "R4 temp unchanged");
        check(32'(reading(0)), 32'h8010, "R4 rail unchanged");

        // R6 equal to limit: no alarm; one step above: alarm
        send(3, 16'd5280);
        check(32'(alarm_hi), 0, "R6 equal no alarm");
        check(32'(temp_ok), 1, "R10 at upper limit");
        send(3, 16'd5281);
        check(32'(alarm_hi), 1, "R6 above limit");
        check(32'(temp_ok), 0, "R10 above window");

        // R8 clear refused while still high
        @(negedge clk); clr_hi = 1;
        @(negedge clk); @(negedge clk);
        check(32'(alarm_hi), 1, "R8 clear refused");
        // R9 held clear applies on the in-range edge
        send(3, 16'd4800);
        check(32'(alarm_hi), 0, "R9 held clear applied");
        clr_hi = 0;

        // R7 below low limit
        send(3, 16'd3999);
        check(32'(alarm_lo), 1, "R7 below limit");
        check(32'(alarm_hi), 0, "R12 high alarm untouched");
        // R12 clr_hi leaves alarm_lo
        @(negedge clk); clr_hi = 1;
        @(negedge clk); clr_hi = 0;
        check(32'(alarm_lo), 1, "R12 clr_hi independent");
        // R8 clr_lo refused while low
        @(negedge clk); clr_lo = 1;
        @(negedge clk); clr_lo = 0;
        check(32'(alarm_lo), 1, "R8 low clear refused");
        // R7 equal to low limit: back in window, alarm sticky until cleared
        send(3, 16'd4000);
        check(32'(alarm_lo), 1, "R8 sticky after return");
        check(32'(temp_ok), 1, "R10 at lower limit");
        @(negedge clk); clr_lo = 1;
        @(negedge clk); clr_lo = 0;
        check(32'(alarm_lo), 0, "R8 low clear accepted");

        // R5 disabled channel ignored
        chan_en = 4'b0111;
        send(3, 16'd1600);
        check(32'(alarm_lo), 0, "R5 no alarm from disabled");
        check(32'(temp_k), 250, "R5 temp held");
        chan_en = 4'b1101;
        send(1, 16'h0001);
        check(32'(reading(1)), 32'h385E, "R5 rail held");
        chan_en = 4'hF;

        repeat (3) @(negedge clk);
        check(32'(exp_ch.size()), 0, "R1 all expected updates seen");
        finish_run();
    end

endmodule